// File: doc/BRIEF.md
# Serial-Output Successive-Approximation Conversion Sequencer

This block is the digital controller for a successive-approximation converter with a serial result port. It works in a fast system clock domain. Three lines come in from outside without timing alignment: a sample line, a conversion clock and a calibration request. The block synchronizes all three. A falling edge on the sample line commits a conversion and sets busy. A short guard window then follows, and conversion clock edges inside it are dropped. After the guard, the search counts `DATA_W+1` conversion clock pulses. Each of the first `DATA_W` rising edges resolves one bit from the comparator decision.

The comparator sits in an abstract analog front end. It compares the held input against the trial code that this block drives. The search runs on an offset-binary trial code. The serial line shifts out the same result in two's complement, MSB first, while the search is still running. A gated copy of the conversion clock marks when each bit can be captured. A calibration request aborts whatever is in progress. Busy then stays high until the request is released and a fixed number of conversion clock pulses have passed.

Top module: `sar_conv_seq`

## Requirements
- R1: When busy is low, a falling edge of `sample_i` commits a conversion and raises `busy_o`. Any change of `sample_i` while busy is high has no effect on the result or on the pulse count.
- R2: After the guard window, a conversion takes exactly `DATA_W+1` rising edges of `conv_clk_i`. `busy_o` stays high after `DATA_W` of them and falls on the last one.
- R3: Rising edges of `conv_clk_i` during the `GUARD_CYC` system cycles after the detected sample fall are dropped and do not count toward R2.
- R4: `cmp_i`=1 means the input is at or above `trial_o`. The trial code starts at midscale, only the MSB set. Each of the first `DATA_W` rising edges fixes one bit from the MSB down. At the end, `trial_o` holds the offset-binary result: the largest code not above the input.
- R5: `sdata_o` carries the result in two's complement (offset-binary result with its MSB inverted), MSB first. Each rising edge of `sclk_o` captures the next bit.
- R6: `sclk_o` pulses only for conversion clock pulses 2 through `DATA_W+1`, giving exactly `DATA_W` rising edges per conversion. It stays low otherwise.
- R7: While busy is low, conversion clock pulses have no effect: `sdata_o`, `trial_o` and `sclk_o` stay unchanged until the next committing sample fall.
- R8: If `sample_i` is raised during a conversion and held through its last pulse, its fall after busy drops starts the next conversion at once, with no idle pulses between.
- R9: `cal_i` high drives `busy_o` high immediately and aborts a running conversion. After `cal_i` returns low, busy stays high for `CAL_CYC` rising edges of `conv_clk_i` and falls on the last one.
- R10: An input below the range gives the most negative two's complement code, and one above the range gives the most positive code, with no wrap.
- R11: After reset `busy_o`, `sclk_o`, `sdata_o` and `trial_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the conversion clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sample_i | input | 1 | Acquisition line; its falling edge commits a conversion |
| conv_clk_i | input | 1 | External conversion clock pulses |
| cal_i | input | 1 | Calibration request, aborts and holds busy while high |
| cmp_i | input | 1 | Comparator decision, 1 when the input is at or above `trial_o` |
| trial_o | output | DATA_W | Offset-binary trial code to the front end |
| busy_o | output | 1 | Conversion or calibration in progress |
| sdata_o | output | 1 | Serial result, two's complement, MSB first |
| sclk_o | output | 1 | Gated conversion clock that marks valid data bits |

## Verification
A wrong pulse count or a missed guard shows at the ports within one conversion. `busy_o` then falls one pulse early or late, and the serial word is shifted by one bit compared with the arithmetic expectation. A wrong trial bit update shows on `trial_o` and in the captured serial word as soon as that conversion ends. The sweep over every code plus both out-of-range sides finds a single bad bit position within the first conversion that needs it. A sequencer that leaves its idle or calibration state wrongly changes `sdata_o`, `trial_o` or `sclk_o` during idle pulses, or drops busy at a calibration count other than `CAL_CYC`.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_GUARD    = 3'd1,
    ST_CONV     = 3'd2,
    ST_TAIL     = 3'd3,
    ST_CAL_HOLD = 3'd4,
    ST_CAL_RUN  = 3'd5
  } seq_st_e;
endpackage

// File: rtl/sar_edge_sync.sv
module sar_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign lvl_o  = sync_q[STAGES-1];
  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int GUARD_CYC = 8,
  parameter int CAL_CYC   = 85532,
  localparam int IDX_W    = $clog2(DATA_W),
  localparam int PCNT_W   = $clog2(DATA_W + 2),
  localparam int GCNT_W   = $clog2(GUARD_CYC + 1),
  localparam int CCNT_W   = $clog2(CAL_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_fall_i,
  input  logic             cclk_rise_i,
  input  logic             cclk_fall_i,
  input  logic             cal_lvl_i,
  output seq_st_e          st_o,
  output logic             busy_o,
  output logic             load_o,
  output logic             step_o,
  output logic [IDX_W-1:0] step_sel_o,
  output logic             shift_o,
  output logic [IDX_W-1:0] shift_sel_o,
  output logic             sclk_en_o,
  output logic             sclk_hold_o
);
  localparam logic [IDX_W-1:0]  TOP_IDX  = IDX_W'(DATA_W - 1);
  localparam logic [PCNT_W-1:0] LAST_P   = PCNT_W'(DATA_W);
  localparam logic [GCNT_W-1:0] GUARD_LD = GCNT_W'(GUARD_CYC - 1);
  localparam logic [CCNT_W-1:0] CAL_LAST = CCNT_W'(CAL_CYC - 1);

  seq_st_e           st_q, st_d;
  logic [PCNT_W-1:0] pcnt_q, pcnt_d;
  logic [GCNT_W-1:0] gcnt_q, gcnt_d;
  logic [CCNT_W-1:0] ccnt_q, ccnt_d;

  always_comb begin
    st_d   = st_q;
    pcnt_d = pcnt_q;
    gcnt_d = gcnt_q;
    ccnt_d = ccnt_q;
    if (cal_lvl_i) begin
      st_d = ST_CAL_HOLD;
    end else begin
      unique case (st_q)
        ST_IDLE, ST_TAIL: begin
          if (smp_fall_i) begin
            st_d   = ST_GUARD;
            gcnt_d = GUARD_LD;
          end else if (st_q == ST_TAIL && cclk_fall_i) begin
            st_d = ST_IDLE;
          end
        end
        ST_GUARD: begin
          if (gcnt_q == '0) begin
            st_d   = ST_CONV;
            pcnt_d = '0;
          end else begin
            gcnt_d = gcnt_q - 1'b1;
          end
        end
        ST_CONV: begin
          if (cclk_rise_i) begin
            pcnt_d = pcnt_q + 1'b1;
            if (pcnt_q == LAST_P) st_d = ST_TAIL;
          end
        end
        ST_CAL_HOLD: begin
          st_d   = ST_CAL_RUN;
          ccnt_d = '0;
        end
        ST_CAL_RUN: begin
          if (cclk_rise_i) begin
            if (ccnt_q == CAL_LAST) st_d = ST_IDLE;
            else ccnt_d = ccnt_q + 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      pcnt_q <= '0;
      gcnt_q <= '0;
      ccnt_q <= '0;
    end else begin
      st_q   <= st_d;
      pcnt_q <= pcnt_d;
      gcnt_q <= gcnt_d;
      ccnt_q <= ccnt_d;
    end
  end

  logic in_conv;
  assign in_conv = (st_q == ST_CONV) && !cal_lvl_i;

  assign st_o        = st_q;
  assign busy_o      = (st_q == ST_GUARD) || (st_q == ST_CONV) ||
                       (st_q == ST_CAL_HOLD) || (st_q == ST_CAL_RUN);
  assign load_o      = (st_q == ST_GUARD) && (gcnt_q == '0) && !cal_lvl_i;
  assign step_o      = in_conv && cclk_rise_i && (pcnt_q < LAST_P);
  assign step_sel_o  = TOP_IDX - pcnt_q[IDX_W-1:0];
  // bit decided on pulse k is presented on the following fall
  assign shift_o     = in_conv && cclk_fall_i && (pcnt_q != '0) && (pcnt_q <= LAST_P);
  assign shift_sel_o = TOP_IDX - (pcnt_q[IDX_W-1:0] - 1'b1);
  assign sclk_en_o   = in_conv && (pcnt_q != '0);
  assign sclk_hold_o = ((st_q == ST_CONV) || (st_q == ST_TAIL)) && !cal_lvl_i;
endmodule

// File: rtl/sar_search.sv
module sar_search #(
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [IDX_W-1:0]  sel_i,
  input  logic              cmp_i,
  output logic [DATA_W-1:0] trial_o
);
  localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);

  logic [DATA_W-1:0] trial_q, trial_d;

  always_comb begin
    trial_d = trial_q;
    if (load_i) begin
      trial_d = MID;
    end else if (step_i) begin
      for (int b = 0; b < DATA_W; b++) begin
        if (sel_i == IDX_W'(b)) begin
          trial_d[b] = cmp_i;
          if (b > 0) trial_d[(b > 0) ? b - 1 : 0] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trial_q <= '0;
    else         trial_q <= trial_d;
  end

  assign trial_o = trial_q;
endmodule

// File: rtl/sar_serial_port.sv
module sar_serial_port #(
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] word_i,
  input  logic              shift_i,
  input  logic [IDX_W-1:0]  sel_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              en_i,
  input  logic              hold_i,
  output logic              sdata_o,
  output logic              sclk_o
);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(DATA_W - 1);

  logic sdata_q, sclk_q;
  logic pick;

  // MSB inverted: offset binary to two's complement
  assign pick = word_i[sel_i] ^ (sel_i == TOP_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sdata_q <= 1'b0;
      sclk_q  <= 1'b0;
    end else begin
      if (shift_i) sdata_q <= pick;
      if (!hold_i)              sclk_q <= 1'b0;
      else if (rise_i && en_i)  sclk_q <= 1'b1;
      else if (fall_i)          sclk_q <= 1'b0;
    end
  end

  assign sdata_o = sdata_q;
  assign sclk_o  = sclk_q;
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_seq_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int GUARD_CYC = 8,
  parameter int CAL_CYC   = 85532,
  parameter int SYNC_STG  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic              conv_clk_i,
  input  logic              cal_i,
  input  logic              cmp_i,
  output logic [DATA_W-1:0] trial_o,
  output logic              busy_o,
  output logic              sdata_o,
  output logic              sclk_o
);
  localparam int IDX_W = $clog2(DATA_W);

  logic smp_lvl, smp_rise, smp_fall;
  logic cc_lvl, cc_rise, cc_fall;
  logic cal_lvl, cal_rise, cal_fall;

  sar_edge_sync #(.STAGES(SYNC_STG)) u_smp_sync (
    .clk_i, .rst_ni, .async_i(sample_i),
    .lvl_o(smp_lvl), .rise_o(smp_rise), .fall_o(smp_fall)
  );
  sar_edge_sync #(.STAGES(SYNC_STG)) u_cc_sync (
    .clk_i, .rst_ni, .async_i(conv_clk_i),
    .lvl_o(cc_lvl), .rise_o(cc_rise), .fall_o(cc_fall)
  );
  sar_edge_sync #(.STAGES(SYNC_STG)) u_cal_sync (
    .clk_i, .rst_ni, .async_i(cal_i),
    .lvl_o(cal_lvl), .rise_o(cal_rise), .fall_o(cal_fall)
  );

  seq_st_e          st;
  logic             busy_q, load, step, shift, sclk_en, sclk_hold;
  logic [IDX_W-1:0] step_sel, shift_sel;

  sar_seq_ctrl #(
    .DATA_W(DATA_W), .GUARD_CYC(GUARD_CYC), .CAL_CYC(CAL_CYC)
  ) u_ctrl (
    .clk_i, .rst_ni,
    .smp_fall_i(smp_fall), .cclk_rise_i(cc_rise), .cclk_fall_i(cc_fall),
    .cal_lvl_i(cal_lvl),
    .st_o(st), .busy_o(busy_q), .load_o(load),
    .step_o(step), .step_sel_o(step_sel),
    .shift_o(shift), .shift_sel_o(shift_sel),
    .sclk_en_o(sclk_en), .sclk_hold_o(sclk_hold)
  );

  sar_search #(.DATA_W(DATA_W)) u_search (
    .clk_i, .rst_ni, .load_i(load), .step_i(step), .sel_i(step_sel),
    .cmp_i, .trial_o
  );

  sar_serial_port #(.DATA_W(DATA_W)) u_ser (
    .clk_i, .rst_ni, .word_i(trial_o), .shift_i(shift), .sel_i(shift_sel),
    .rise_i(cc_rise), .fall_i(cc_fall), .en_i(sclk_en), .hold_i(sclk_hold),
    .sdata_o, .sclk_o
  );

  // request path bypasses the synchronizer so busy rises at once
  assign busy_o = busy_q | cal_i;

  logic unused_lvls;
  assign unused_lvls = ^{smp_lvl, smp_rise, cc_lvl, cal_rise, cal_fall};
endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk
  import sar_seq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cal_i,
  input logic              busy_o,
  input logic              sclk_o,
  input logic              sdata_o,
  input logic [DATA_W-1:0] trial_o,
  input seq_st_e           st_i
);
  localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);

  a_r9_cal_forces_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_i |-> busy_o);

  a_r7_sdata_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && $past(!busy_o)) |-> $stable(sdata_o));

  a_r7_trial_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && $past(!busy_o)) |-> $stable(trial_o));

  a_r6_sclk_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> ($past(st_i) == ST_CONV || $past(st_i) == ST_TAIL));

  a_r4_midscale_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_CONV && $past(st_i) == ST_GUARD) |-> trial_o == MID);
endmodule

bind sar_conv_seq sar_conv_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cal_i(cal_i), .busy_o(busy_o),
  .sclk_o(sclk_o), .sdata_o(sdata_o), .trial_o(trial_o), .st_i(st)
);

// File: tb/tb_sar_conv_seq.sv
module tb_sar_conv_seq;
  localparam int W     = 8;
  localparam int GUARD = 6;
  localparam int CALN  = 40;
  localparam int MAXV  = (1 << W) - 1;

  logic clk = 0, rst_n = 0;
  logic sample = 0, cclk = 0, cal = 0;
  logic [W-1:0] trial;
  logic busy, sdata, sclk, cmp;
  int vin = 0;
  int checks = 0, fails = 0, scnt = 0, cycles = 0;
  logic [W-1:0] cap = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sar_conv_seq #(.DATA_W(W), .GUARD_CYC(GUARD), .CAL_CYC(CALN)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .conv_clk_i(cclk),
    .cal_i(cal), .cmp_i(cmp), .trial_o(trial), .busy_o(busy),
    .sdata_o(sdata), .sclk_o(sclk)
  );

  assign cmp = (vin >= int'(trial));

  always @(posedge sclk) begin
    cap  = {cap[W-2:0], sdata};
    scnt = scnt + 1;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(int hi, int lo);
    @(negedge clk) cclk = 1;
    wait_n(hi);
    cclk = 0;
    wait_n(lo);
  endtask

  task automatic commit();
    @(negedge clk) sample = 1;
    wait_n(4);
    sample = 0;
    wait_n(GUARD + 6);
  endtask

  function automatic int clampv(int v);
    return (v < 0) ? 0 : (v > MAXV) ? MAXV : v;
  endfunction

  function automatic int twos(int v);
    return clampv(v) ^ (1 << (W - 1));
  endfunction

  task automatic finish_check(int v, string req);
    chk(int'(trial) == clampv(v), {req, " R4 trial"}, int'(trial), clampv(v));
    chk(int'(cap) == twos(v), {req, " R5 serial"}, int'(cap), twos(v));
  endtask

  task automatic full_conv(int v, string req);
    int s0;
    vin = v;
    s0 = scnt;
    commit();
    for (int i = 0; i < W; i++) pulse(4, 4);
    chk(busy == 1'b1, "R2 busy before last pulse", int'(busy), 1);
    pulse(4, 6);
    chk(busy == 1'b0, "R2 busy after last pulse", int'(busy), 0);
    chk(scnt - s0 == W, "R6 sclk count", scnt - s0, W);
    finish_check(v, req);
  endtask

  initial begin
    wait_n(3);
    chk(busy == 0 && sclk == 0 && sdata == 0 && trial == 0, "R11 reset", int'(busy), 0);
    rst_n = 1;
    wait_n(4);
    chk(busy == 0 && trial == 0, "R11 after release", int'(trial), 0);

    for (int v = 0; v <= MAXV; v++) full_conv(v, "sweep");

    full_conv(-5, "R10 below");
    full_conv(MAXV + 9, "R10 above");

    begin : idle_pulses
      logic sd0; logic [W-1:0] tr0; int s0;
      sd0 = sdata; tr0 = trial; s0 = scnt;
      for (int i = 0; i < 3; i++) pulse(4, 4);
      chk(sdata == sd0, "R7 sdata held", int'(sdata), int'(sd0));
      chk(trial == tr0, "R7 trial held", int'(trial), int'(tr0));
      chk(scnt == s0, "R7 no sclk", scnt - s0, 0);
      chk(busy == 0, "R7 busy low", int'(busy), 0);
    end

    begin : guard_drop
      int s0;
      vin = 77; s0 = scnt;
      @(negedge clk) sample = 1;
      wait_n(4);
      sample = 0;
      wait_n(1);
      pulse(2, 2);
      wait_n(GUARD + 6);
      for (int i = 0; i < W; i++) pulse(4, 4);
      chk(busy == 1, "R3 early pulse not counted", int'(busy), 1);
      pulse(4, 6);
      chk(busy == 0, "R3 ends on last pulse", int'(busy), 0);
      chk(scnt - s0 == W, "R3 sclk count", scnt - s0, W);
      finish_check(77, "R3");
    end

    begin : sample_ignored
      int s0;
      vin = 150; s0 = scnt;
      commit();
      for (int i = 0; i < 3; i++) pulse(4, 4);
      @(negedge clk) sample = 1;
      wait_n(4);
      sample = 0;
      for (int i = 3; i < W; i++) pulse(4, 4);
      chk(busy == 1, "R1 busy held", int'(busy), 1);
      pulse(4, 6);
      chk(busy == 0, "R1 ignored sample fall", int'(busy), 0);
      chk(scnt - s0 == W, "R1 sclk count", scnt - s0, W);
      finish_check(150, "R1");
    end

    begin : continuous
      int s0;
      vin = 33;
      commit();
      for (int i = 0; i < W; i++) pulse(4, 4);
      @(negedge clk) sample = 1;
      pulse(4, 6);
      chk(busy == 0, "R8 first ends", int'(busy), 0);
      finish_check(33, "R8 first");
      s0 = scnt;
      vin = 201;
      sample = 0;
      wait_n(GUARD + 6);
      chk(busy == 1, "R8 next committed", int'(busy), 1);
      for (int i = 0; i <= W; i++) pulse(4, 4);
      wait_n(2);
      chk(busy == 0, "R8 second ends", int'(busy), 0);
      chk(scnt - s0 == W, "R8 sclk count", scnt - s0, W);
      finish_check(201, "R8 second");
    end

    begin : calib
      vin = 90;
      commit();
      for (int i = 0; i < 3; i++) pulse(4, 4);
      @(negedge clk) cal = 1;
      #1;
      chk(busy == 1, "R9 busy immediate", int'(busy), 1);
      wait_n(5);
      cal = 0;
      wait_n(6);
      chk(busy == 1, "R9 busy after release", int'(busy), 1);
      for (int i = 0; i < CALN - 1; i++) pulse(4, 4);
      chk(busy == 1, "R9 busy before last cal pulse", int'(busy), 1);
      pulse(4, 6);
      chk(busy == 0, "R9 busy after cal", int'(busy), 0);
      full_conv(12, "R9 post cal");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000 && !done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule